// File: doc/BRIEF.md
# Encoder Serial Master with Cable-Delay Compensation

This block is the master end of a point-to-point link to an absolute-position encoder. It generates the encoder clock from the system clock and captures the returning serial data line. Over a long cable the reply arrives late by an amount that may be any fraction of a clock period. Shifting the received word by whole bits cannot undo that. The master therefore does not sample relative to its own clock edges. It watches the data line at system-clock resolution and waits for the acknowledge (line pulled low) followed by the start bit (line returning high). That rising edge starts a local bit timer. Every following data bit is sampled a fixed number of system cycles into its window. The received word comes out right-aligned, with no shifting after capture.

A frame begins with a one-cycle start pulse. The divider, sample-phase choice, frame length, acknowledge limit and idle hold time are sampled at that moment. The encoder clock then runs without gaps until the last data bit has been taken. It then returns high and stays high for the programmed hold time before another start is accepted. If no start bit is seen within the acknowledge limit, the frame is abandoned with a timeout flag.

Top module: `enc_link_master`

## Requirements
- R1: The encoder clock is high out of reset, between frames and during the hold time; each frame's first encoder-clock transition is a falling edge.
- R2: During a frame every low and every high phase of the encoder clock lasts exactly `half_div_i` system cycles, taken at start and raised to 4 if smaller, so the divide ratio is at least 8, with no gap in the clock until the last bit is captured.
- R3: Capture aligns to a low level on the data line followed by its return high (the start bit). The data bits that follow, one per encoder clock with the first one received first, are recovered correctly for any cable delay, whole or fractional, and for acknowledge lengths of one or more clocks.
- R4: With `late_sample_i` = 0 each data bit is sampled `half_div` system cycles after its window opens, measured from the start-bit edge. With `late_sample_i` = 1 it is sampled floor(3*`half_div`/2) cycles after.
- R5: The result is right-aligned: `frame_len_i` bits (1 to 32) occupy `pos_o[frame_len_i-1:0]`, the first received bit at position `frame_len_i-1`, and all higher bits read 0.
- R6: `pos_valid_o` is high for exactly one cycle per completed frame, and `pos_o` keeps that word until the next frame starts.
- R7: If the start bit has not been detected by the `ack_limit_i`-th falling encoder-clock edge, `timeout_err_o` rises together with that edge and `pos_valid_o` stays low. The encoder clock returns high within one half period. The flag clears when the next frame is accepted.
- R8: After the clock returns high at the end of a frame, it stays high for at least `idle_hold_i` plus `half_div` system cycles before the next frame's first fall. A start pulse while a frame or the hold time is in progress is ignored.
- R9: Once the last data bit is captured, no further falling edge is produced on the encoder clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a frame (accepted only when idle) |
| half_div_i | input | 8 | Encoder-clock half period in system cycles (min 4) |
| late_sample_i | input | 1 | Sample-phase select: 0 mid-window, 1 three-quarter window |
| frame_len_i | input | 6 | Number of data bits after the start bit |
| ack_limit_i | input | 8 | Falling edges allowed before timeout |
| idle_hold_i | input | 16 | System cycles of high clock after a frame |
| enc_data_i | input | 1 | Serial data returning from the encoder |
| enc_clk_o | output | 1 | Clock to the encoder |
| pos_o | output | 32 | Captured position word, right-aligned |
| pos_valid_o | output | 1 | One-cycle strobe when a frame completes |
| timeout_err_o | output | 1 | No start bit within the acknowledge limit |

## Verification
The bench uses cable delays that are not multiples of the encoder period, such as 3/8 and 11/8 of a period. A master that sampled at fixed clock edges, or that only shifted whole bits, would return words with smeared or doubled bits there. Long acknowledges, a one-bit frame, a full 32-bit frame and a short frame fed an all-ones word are aimed at off-by-one bit counts and stale upper bits. A divider below the minimum, back-to-back start requests and a start pulse arriving during a frame's tail expose a clock that runs too fast, a hold time that is cut short, or a stray extra frame. A silent encoder checks that the timeout fires on exactly the programmed falling edge and that the clock is parked high, not left low.

// File: rtl/enc_master_pkg.sv
package enc_master_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_STOP,
        ST_HOLD
    } link_state_e;

    localparam int unsigned MIN_HALF = 4;

    // Offset into a bit window at which the data line is sampled.
    function automatic int unsigned sample_offset(input int unsigned half, input logic late);
        return late ? (half + half / 2) : half;
    endfunction

    function automatic int unsigned clamp_half(input int unsigned half);
        return (half < MIN_HALF) ? MIN_HALF : half;
    endfunction

endpackage

// File: rtl/enc_clk_gen.sv
module enc_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             ma,
    output logic             fall_p
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick   = run && (cnt == half_div - DIV_W'(1));
    assign fall_p = tick && ma;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            ma  <= 1'b1;
        end else if (tick) begin
            cnt <= '0;
            ma  <= ~ma;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R1: once stopped, the clock is parked high
    a_r1_park_high: assert property (@(posedge clk) disable iff (rst)
        !run |=> ma);

endmodule

// File: rtl/enc_rx_align.sv
module enc_rx_align #(
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              en,
    input  logic              sdi,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              late,
    input  logic [LEN_W-1:0]  frame_len,
    output logic              locked,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    import enc_master_pkg::*;

    localparam int TW = DIV_W + 2;

    logic          s1, s2, s3;
    logic          seen_low;
    logic [TW-1:0] tmr;
    logic [TW-1:0] period;
    logic [TW-1:0] offset;
    logic [LEN_W-1:0] nbits;
    logic          start_edge;

    assign period     = TW'({half_div, 1'b0});
    assign offset     = TW'(sample_offset(int'(half_div), late));
    assign start_edge = seen_low && s2 && !s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= sdi;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_low <= 1'b0;
            locked   <= 1'b0;
            tmr      <= '0;
            nbits    <= '0;
            data     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                seen_low <= 1'b0;
                locked   <= 1'b0;
                tmr      <= '0;
                nbits    <= '0;
                data     <= '0;
            end else if (en) begin
                if (!locked) begin
                    if (!s2) seen_low <= 1'b1;
                    if (start_edge) begin
                        locked <= 1'b1;
                        tmr    <= period + offset - TW'(1);
                    end
                end else if (nbits != frame_len) begin
                    if (tmr == '0) begin
                        data  <= {data[DATA_W-2:0], s2};
                        nbits <= nbits + LEN_W'(1);
                        tmr   <= period - TW'(1);
                        if (nbits + LEN_W'(1) == frame_len) done <= 1'b1;
                    end else begin
                        tmr <= tmr - TW'(1);
                    end
                end
            end
        end
    end

    // R5: bits above the frame length are zero when the word is presented
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> ((data >> frame_len) == '0));
    // R6: completion is a single-cycle event
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3: no data is taken before the start-bit edge has been found
    a_r3_lock_first: assert property (@(posedge clk) disable iff (rst)
        (!locked && !arm) |=> (nbits == '0));

endmodule

// File: rtl/enc_link_master.sv
module enc_link_master #(
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 6,
    parameter int DATA_W = 32,
    parameter int LIM_W  = 8,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic              late_sample_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic [LIM_W-1:0]  ack_limit_i,
    input  logic [HOLD_W-1:0] idle_hold_i,
    input  logic              enc_data_i,
    output logic              enc_clk_o,
    output logic [DATA_W-1:0] pos_o,
    output logic              pos_valid_o,
    output logic              timeout_err_o
);
    import enc_master_pkg::*;

    link_state_e       state;
    logic [DIV_W-1:0]  half_q;
    logic              late_q;
    logic [LEN_W-1:0]  len_q;
    logic [LIM_W-1:0]  lim_q;
    logic [HOLD_W-1:0] hold_q;
    logic [LIM_W-1:0]  fall_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              run;
    logic              arm;
    logic              fall_p;
    logic              locked;
    logic              rx_done;
    logic              err_q;

    assign arm = (state == ST_IDLE) && start_i;
    // The clock keeps running until the last bit; a high phase is never cut
    // into a fall after the frame is complete.
    assign run = ((state == ST_RUN) && !(rx_done && enc_clk_o)) ||
                 ((state == ST_STOP) && !enc_clk_o);

    enc_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_q),
        .ma       (enc_clk_o),
        .fall_p   (fall_p)
    );

    enc_rx_align #(.DIV_W(DIV_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .en        (state == ST_RUN),
        .sdi       (enc_data_i),
        .half_div  (half_q),
        .late      (late_q),
        .frame_len (len_q),
        .locked    (locked),
        .done      (rx_done),
        .data      (pos_o)
    );

    assign pos_valid_o   = rx_done;
    assign timeout_err_o = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            half_q   <= DIV_W'(MIN_HALF);
            late_q   <= 1'b0;
            len_q    <= LEN_W'(1);
            lim_q    <= '1;
            hold_q   <= '0;
            fall_cnt <= '0;
            hold_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        half_q   <= DIV_W'(clamp_half(int'(half_div_i)));
                        late_q   <= late_sample_i;
                        len_q    <= (frame_len_i == '0) ? LEN_W'(1) :
                                    (frame_len_i > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : frame_len_i;
                        lim_q    <= (ack_limit_i == '0) ? LIM_W'(1) : ack_limit_i;
                        hold_q   <= idle_hold_i;
                        fall_cnt <= '0;
                        err_q    <= 1'b0;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (rx_done) begin
                        state <= ST_STOP;
                    end else if (fall_p && !locked) begin
                        fall_cnt <= fall_cnt + LIM_W'(1);
                        if (fall_cnt + LIM_W'(1) == lim_q) begin
                            err_q <= 1'b1;
                            state <= ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    if (enc_clk_o) begin
                        hold_cnt <= '0;
                        state    <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if ((HOLD_W+1)'(hold_cnt) + (HOLD_W+1)'(1) >= (HOLD_W+1)'(hold_q))
                        state <= ST_IDLE;
                    else
                        hold_cnt <= hold_cnt + HOLD_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // ---- assertion support: length of the current low phase ----
    logic [DIV_W:0] low_len;
    always_ff @(posedge clk) begin
        if (rst || enc_clk_o) low_len <= '0;
        else                  low_len <= low_len + (DIV_W+1)'(1);
    end

    // R1: clock is high whenever no frame is running
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_HOLD) |-> enc_clk_o);
    // R2: every low phase lasts exactly the latched half period
    a_r2_low_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(enc_clk_o) |-> (low_len == (DIV_W+1)'(half_q)));
    // R7: a timeout never comes with a valid word
    a_r7_err_no_valid: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |-> !pos_valid_o);
    // R7: timeout ends the running part of the frame
    a_r7_err_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err_o) |-> (state == ST_STOP));
    // R9: no falling clock edge after the word is complete
    a_r9_no_fall_after: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |=> !$fell(enc_clk_o));

endmodule

// File: tb/tb_enc_link_master.sv
`timescale 1ns/1ps
module tb_enc_link_master;

    localparam int HOLD = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  half_div_i = 8'd4;
    logic        late_sample_i = 1'b0;
    logic [5:0]  frame_len_i = 6'd8;
    logic [7:0]  ack_limit_i = 8'd20;
    logic [15:0] idle_hold_i = 16'(HOLD);
    logic        enc_data_i;
    logic        enc_clk_o;
    logic [31:0] pos_o;
    logic        pos_valid_o;
    logic        timeout_err_o;

    always #2.5 clk = ~clk;

    enc_link_master dut (
        .clk(clk), .rst(rst), .start_i(start_i), .half_div_i(half_div_i),
        .late_sample_i(late_sample_i), .frame_len_i(frame_len_i),
        .ack_limit_i(ack_limit_i), .idle_hold_i(idle_hold_i),
        .enc_data_i(enc_data_i), .enc_clk_o(enc_clk_o), .pos_o(pos_o),
        .pos_valid_o(pos_valid_o), .timeout_err_o(timeout_err_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- encoder model with cable delay ----------------
    logic [31:0] enc_word = '0;
    int          enc_len  = 8;
    int          enc_ack  = 1;
    bit          enc_mute = 0;
    int          dly      = 0;
    int          enc_r    = 0;
    int          hi_e     = 0;
    logic        ma_q     = 1'b1;
    logic        enc_raw  = 1'b1;
    logic [63:0] dl       = '1;

    function automatic logic enc_bit(input int r);
        int k;
        if (enc_mute) return 1'b1;
        if (r >= 2 && r <= 1 + enc_ack) return 1'b0;
        if (r == 2 + enc_ack) return 1'b1;
        k = r - 3 - enc_ack;
        if (k >= 0 && k < enc_len) return enc_word[enc_len-1-k];
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        ma_q <= enc_clk_o;
        dl   <= {dl[62:0], enc_raw};
        if (enc_clk_o) hi_e <= hi_e + 1; else hi_e <= 0;
        if (!ma_q && enc_clk_o) begin
            enc_r   <= enc_r + 1;
            enc_raw <= enc_bit(enc_r + 1);
        end else if (hi_e > 20) begin
            enc_r   <= 0;
            enc_raw <= 1'b1;
        end
    end

    always_comb enc_data_i = (dly == 0) ? enc_raw : dl[dly-1];

    // ---------------- scoreboard monitor ----------------
    logic [31:0] exp_q[$];
    string cur_tag  = "R3";
    int    cur_half = 4;
    logic  v_prev   = 1'b0;
    logic  ma_prev  = 1'b1;
    int    lo_run   = 0;
    int    hi_run   = 100;

    always @(negedge clk) begin
        if (!rst) begin
            if (pos_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected valid", 1, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(pos_o == e, cur_tag, "received word", 64'(pos_o), 64'(e));
                end
                if (v_prev) check(1'b0, "R6", "valid longer than one cycle", 2, 1);
            end
            v_prev = pos_valid_o;
            // R2: phase lengths inside a frame
            if (enc_clk_o && !ma_prev && lo_run > 0)
                check(lo_run == cur_half, "R2", "low phase length", lo_run, cur_half);
            if (!enc_clk_o && ma_prev && hi_run < 3 * cur_half)
                check(hi_run == cur_half, "R2", "high phase length", hi_run, cur_half);
            if (enc_clk_o) begin
                hi_run = ma_prev ? hi_run + 1 : 1;
                lo_run = 0;
            end else begin
                lo_run = ma_prev ? 1 : lo_run + 1;
            end
            ma_prev = enc_clk_o;
        end
    end

    function automatic logic [31:0] masked(input logic [31:0] w, input int len);
        return (len >= 32) ? w : (w & ((32'd1 << len) - 32'd1));
    endfunction

    // poke: 0 none, 1 ignored start after valid, 2 held start for next frame
    task automatic do_frame(input int half, input bit late, input int len,
                            input logic [31:0] word, input int ack, input int d,
                            input int poke, input string tag);
        int t;
        logic pm;
        int falls;
        int hi;
        @(negedge clk);
        half_div_i    = 8'(half);
        late_sample_i = late;
        frame_len_i   = 6'(len);
        ack_limit_i   = 8'd20;
        idle_hold_i   = 16'(HOLD);
        enc_word      = word;
        enc_len       = len;
        enc_ack       = ack;
        enc_mute      = 0;
        dly           = d;
        cur_half      = (half < 4) ? 4 : half;
        cur_tag       = tag;
        exp_q.push_back(masked(word, len));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 0;
        while (!pos_valid_o && t < 4000) begin @(negedge clk); t++; end
        check(pos_valid_o, tag, "frame completed", 64'(pos_valid_o), 1);
        check(!timeout_err_o, "R7", "no error on good frame", 64'(timeout_err_o), 0);
        if (poke == 1) begin
            // R8: start during the frame tail is ignored
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            falls = 0;
            pm = enc_clk_o;
            repeat (HOLD + 4 * cur_half) begin
                @(negedge clk);
                if (pm && !enc_clk_o) falls++;
                pm = enc_clk_o;
            end
            check(falls == 0, "R8", "falls after ignored start", falls, 0);
        end else if (poke == 2) begin
            // R8: held start waits out the hold time
            exp_q.push_back(masked(word, len));
            start_i = 1'b1;
            hi = 0;
            pm = enc_clk_o;
            t = 0;
            while (!(pm && !enc_clk_o) && t < 2000) begin
                @(negedge clk);
                t++;
                if (!(pm && !enc_clk_o)) begin
                    if (enc_clk_o) hi = hi + 1; else hi = 0;
                    pm = enc_clk_o;
                end
            end
            start_i = 1'b0;
            check(hi >= HOLD + cur_half, "R8", "high time before next frame", hi, HOLD + cur_half);
            t = 0;
            while (!pos_valid_o && t < 4000) begin @(negedge clk); t++; end
            check(pos_valid_o, "R8", "queued frame completed", 64'(pos_valid_o), 1);
        end
        repeat (HOLD / 2) @(negedge clk);
        check(enc_clk_o == 1'b1, "R1", "clock high after frame", 64'(enc_clk_o), 1);
        check(pos_o == masked(word, len), "R6", "word held after frame", 64'(pos_o), 64'(masked(word, len)));
        repeat (HOLD + 4) @(negedge clk);
    endtask

    task automatic do_timeout(input int lim);
        int t;
        int falls;
        logic pm;
        @(negedge clk);
        half_div_i  = 8'd4;
        ack_limit_i = 8'(lim);
        enc_mute    = 1;
        cur_half    = 4;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        falls = 0;
        pm = enc_clk_o;
        t = 0;
        while (!timeout_err_o && t < 2000) begin
            @(negedge clk);
            t++;
            if (pm && !enc_clk_o) falls++;
            pm = enc_clk_o;
        end
        check(timeout_err_o, "R7", "timeout flag", 64'(timeout_err_o), 1);
        check(falls == lim, "R7", "falls before timeout", falls, lim);
        repeat (cur_half + 2) @(negedge clk);
        check(enc_clk_o == 1'b1, "R7", "clock parked high after timeout", 64'(enc_clk_o), 1);
        check(timeout_err_o, "R7", "flag held until next start", 64'(timeout_err_o), 1);
        repeat (HOLD + 8) @(negedge clk);
        enc_mute = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(enc_clk_o == 1'b1, "R1", "clock high after reset", 64'(enc_clk_o), 1);
        check(!pos_valid_o, "R6", "valid low after reset", 64'(pos_valid_o), 0);
        check(!timeout_err_o, "R7", "error low after reset", 64'(timeout_err_o), 0);
        repeat (30) @(negedge clk);

        do_frame(4, 0, 24, 32'hA5C31E, 1, 0, 0, "R3");    // R3 no delay
        do_frame(4, 0, 24, 32'h5A3C71, 1, 3, 0, "R3");    // R3 3/8 period delay
        do_frame(4, 0, 16, 32'hBEEF, 3, 11, 0, "R3");     // R3 long ack, 11/8 period
        do_frame(4, 1, 16, 32'h1234, 1, 5, 0, "R4");      // R4 late sample point
        do_frame(6, 1, 20, 32'h9F00D, 2, 21, 0, "R4");    // R4 late, other divider
        do_frame(6, 0, 20, 32'h6A5A5, 1, 17, 0, "R4");    // R4 mid sample point
        do_frame(5, 0, 32, 32'hDEADBEEF, 1, 7, 0, "R5");  // R5 full width
        do_frame(4, 0, 1, 32'h1, 1, 2, 0, "R5");          // R5 single bit
        do_frame(4, 0, 13, 32'hFFFFFFFF, 1, 9, 0, "R5");  // R5 upper bits zero
        do_frame(2, 0, 12, 32'hABC, 1, 4, 0, "R2");       // R2 divider raised to 4
        do_timeout(6);                                     // R7
        do_frame(4, 0, 10, 32'h2C5, 1, 6, 0, "R7");       // R7 flag cleared by new frame
        do_frame(4, 0, 12, 32'h9A6, 1, 13, 1, "R8");      // R8 ignored start, R9 no extra fall
        do_frame(5, 1, 18, 32'h2BEEF, 2, 9, 2, "R8");     // R8 hold before next frame

        check(exp_q.size() == 0, "R6", "all expected words seen", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule